// File: doc/BRIEF.md
# Wait-for-event sleep controller

This block carries out the low-power hint operations of one processing element. It handles wait-for-event, wait-for-interrupt, send-event and send-event-local. A single hint strobe carries a 7-bit selector. The block decides among three outcomes: finish at once, raise a trap request toward a more privileged exception level, or put the element to sleep until a wake condition arrives.

The block holds a one-bit event register. Incoming events from other cores and locally issued events set it. A wait-for-event that finds the register set consumes it and completes without sleeping. A wait that does not complete at once runs a fixed three-step trap check (EL1, then EL2, then EL3), and the first enabled, applicable stage wins. Wait-for-interrupt skips all of this when an interrupt is already pending.

Top module: `wfx_sleep_ctrl`

## Requirements
- R1: After reset, done, trap_req, trap_el, trap_is_wfi, sleeping and sev_out are 0, and the event register is 0. A first wait-for-event with no trap enabled therefore sleeps.
- R2: The selector codes are 7'b0000010 wait-for-event, 7'b0000011 wait-for-interrupt, 7'b0000100 send-event and 7'b0000101 send-event-local. Every other code is accepted and completes with done high in the cycle after acceptance, with no other effect.
- R3: A wait-for-event accepted while the event register is 1 clears the register. It completes with done in the next cycle, with no trap and no sleep, whatever the trap enables are.
- R4: A wait-for-event with the event register 0 checks stages in order. Stage 1 (target 1) applies when cur_el is 0. Stage 2 (target 2) applies when cur_el is 0 or 1, el2_en is 1 and host_mode is 0. Stage 3 (target 3) applies when el3_impl is 1 and cur_el is not 3. The first stage that applies and has its wfe_trap_en bit set (bit 0 for stage 1, bit 1 for stage 2, bit 2 for stage 3) fires. In the next cycle trap_req is 1 for one cycle, trap_el holds the target and trap_is_wfi is 0, while done and sleeping stay 0.
- R5: A wait-for-event with the event register 0 and no firing stage sets sleeping from the next cycle on.
- R6: A wait-for-interrupt accepted while irq_pend is 1 completes with done in the next cycle, with no trap and no sleep.
- R7: A wait-for-interrupt with irq_pend 0 uses the same stage order with the wfi_trap_en bits and reports trap_is_wfi 1. With no firing stage it sleeps.
- R8: Send-event pulses sev_out for exactly one cycle, in the cycle after acceptance, together with done, and sets the local event register. Send-event-local sets the register and leaves sev_out low.
- R9: While sleeping on wait-for-event, a 1 on ext_event, a 1 on irq_pend or a set event register ends the sleep at the next edge. done then pulses for one cycle and the event register is left clear.
- R10: While sleeping on wait-for-interrupt, only irq_pend ends the sleep. An ext_event pulse in that state does not wake the element but does set the event register.
- R11: ext_event outside a wait-for-event sleep sets the event register. When a set and a clear of the register fall in the same cycle, the set wins.
- R12: hint_valid is ignored while sleeping and in the one-cycle response state that follows an accepted hint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hint_valid | input | 1 | Hint strobe |
| hint_sel | input | 7 | Hint selector (CRm:op2) |
| cur_el | input | 2 | Current exception level |
| el2_en | input | 1 | EL2 enabled |
| host_mode | input | 1 | Host mode active |
| el3_impl | input | 1 | EL3 implemented |
| wfe_trap_en | input | 3 | Per-stage trap enables for wait-for-event |
| wfi_trap_en | input | 3 | Per-stage trap enables for wait-for-interrupt |
| irq_pend | input | 1 | Interrupt pending |
| ext_event | input | 1 | Event from another core |
| trap_req | output | 1 | Trap request pulse |
| trap_el | output | 2 | Trap target level |
| trap_is_wfi | output | 1 | Trap came from wait-for-interrupt |
| sleeping | output | 1 | Element is in low-power wait |
| sev_out | output | 1 | Broadcast send-event pulse |
| done | output | 1 | Hint completed or sleep ended |

## Verification
The bench builds the block with its default parameters: three trap stages and a 2-bit level field. With these values every exception level from 0 to 3 can be driven, so each stage's applicability condition can be made true or false on its own. The stage-order cases switch enable bits off one at a time to show that the later stages are reached only when the earlier ones are off. Host mode and level 3 are used to show that a stage is skipped even when its enable bit is set.

// File: rtl/wfx_pkg.sv
package wfx_pkg;
  localparam int SEL_W = 7;

  typedef enum logic [2:0] {
    OP_OTHER = 3'd0,
    OP_WFE   = 3'd1,
    OP_WFI   = 3'd2,
    OP_SEV   = 3'd3,
    OP_SEVL  = 3'd4
  } hint_op_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RESP    = 2'd1,
    ST_SLP_WFE = 2'd2,
    ST_SLP_WFI = 2'd3
  } ctl_st_e;

  function automatic hint_op_e decode_hint(input logic [SEL_W-1:0] sel);
    case (sel)
      7'b0000010: decode_hint = OP_WFE;
      7'b0000011: decode_hint = OP_WFI;
      7'b0000100: decode_hint = OP_SEV;
      7'b0000101: decode_hint = OP_SEVL;
      default:    decode_hint = OP_OTHER;
    endcase
  endfunction

  // Whether trap stage lvl (1..3) applies in the present context
  function automatic logic stage_applies(input int lvl, input logic [1:0] el,
                                         input logic el2_on, input logic host,
                                         input logic el3_on);
    case (lvl)
      1:       stage_applies = (el == 2'd0);
      2:       stage_applies = (el <= 2'd1) && el2_on && !host;
      3:       stage_applies = el3_on && (el != 2'd3);
      default: stage_applies = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/wfx_hint_decode.sv
module wfx_hint_decode
  import wfx_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output logic             is_wfe,
  output logic             is_wfi,
  output logic             is_sev,
  output logic             is_sevl
);
  hint_op_e op;
  assign op      = decode_hint(sel);
  assign is_wfe  = (op == OP_WFE);
  assign is_wfi  = (op == OP_WFI);
  assign is_sev  = (op == OP_SEV);
  assign is_sevl = (op == OP_SEVL);
endmodule

// File: rtl/wfx_trap_sel.sv
module wfx_trap_sel
  import wfx_pkg::*;
#(
  parameter int NUM_LVL = 3,
  parameter int EL_W    = 2
) (
  input  logic [EL_W-1:0]    cur_el,
  input  logic               el2_en,
  input  logic               host_mode,
  input  logic               el3_impl,
  input  logic [NUM_LVL-1:0] en,
  output logic               hit,
  output logic [EL_W-1:0]    tgt
);
  logic [NUM_LVL-1:0] applies;
  logic [NUM_LVL-1:0] fires;

  generate
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_stage
      assign applies[g] = stage_applies(g + 1, cur_el, el2_en, host_mode, el3_impl);
      assign fires[g]   = applies[g] & en[g];
    end
  endgenerate

  // Lowest stage wins: scan downward so the last hit written is the first stage
  always_comb begin
    hit = 1'b0;
    tgt = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (fires[i]) begin
        hit = 1'b1;
        tgt = EL_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/wfx_event_reg.sv
module wfx_event_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic ev_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ev_q <= 1'b0;
    else if (set_i) ev_q <= 1'b1;
    else if (clr_i) ev_q <= 1'b0;
  end

  // R11
  ev_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> ev_q);
endmodule

// File: rtl/wfx_sleep_ctrl.sv
module wfx_sleep_ctrl
  import wfx_pkg::*;
#(
  parameter int NUM_LVL = 3,
  parameter int EL_W    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hint_valid,
  input  logic [6:0]         hint_sel,
  input  logic [EL_W-1:0]    cur_el,
  input  logic               el2_en,
  input  logic               host_mode,
  input  logic               el3_impl,
  input  logic [NUM_LVL-1:0] wfe_trap_en,
  input  logic [NUM_LVL-1:0] wfi_trap_en,
  input  logic               irq_pend,
  input  logic               ext_event,
  output logic               trap_req,
  output logic [EL_W-1:0]    trap_el,
  output logic               trap_is_wfi,
  output logic               sleeping,
  output logic               sev_out,
  output logic               done
);
  ctl_st_e state_q, state_d;
  logic is_wfe, is_wfi, is_sev, is_sevl;
  logic accept, ev_q, hit;
  logic [EL_W-1:0] tgt;
  logic [NUM_LVL-1:0] sel_en;
  logic wfe_acc, wfi_acc, wfe_consume, wfe_trap, wfe_sleep;
  logic wfi_now, wfi_trap, wfi_sleep, trap_any, sleep_any;
  logic wake_wfe, wake_wfi, wake_any, ev_set, ev_clr;

  assign accept = (state_q == ST_IDLE) && hint_valid;

  wfx_hint_decode u_dec (
    .sel(hint_sel), .is_wfe(is_wfe), .is_wfi(is_wfi),
    .is_sev(is_sev), .is_sevl(is_sevl)
  );

  assign sel_en = is_wfi ? wfi_trap_en : wfe_trap_en;

  wfx_trap_sel #(.NUM_LVL(NUM_LVL), .EL_W(EL_W)) u_trap (
    .cur_el(cur_el), .el2_en(el2_en), .host_mode(host_mode),
    .el3_impl(el3_impl), .en(sel_en), .hit(hit), .tgt(tgt)
  );

  // Outcome of an accepted hint
  assign wfe_acc     = accept && is_wfe;
  assign wfi_acc     = accept && is_wfi;
  assign wfe_consume = wfe_acc && ev_q;
  assign wfe_trap    = wfe_acc && !ev_q && hit;
  assign wfe_sleep   = wfe_acc && !ev_q && !hit;
  assign wfi_now     = wfi_acc && irq_pend;
  assign wfi_trap    = wfi_acc && !irq_pend && hit;
  assign wfi_sleep   = wfi_acc && !irq_pend && !hit;
  assign trap_any    = wfe_trap || wfi_trap;
  assign sleep_any   = wfe_sleep || wfi_sleep;

  // Wake conditions
  assign wake_wfe = (state_q == ST_SLP_WFE) && (ev_q || ext_event || irq_pend);
  assign wake_wfi = (state_q == ST_SLP_WFI) && irq_pend;
  assign wake_any = wake_wfe || wake_wfi;

  // An event that ends a wait-for-event sleep is consumed, not latched
  assign ev_set = (ext_event && (state_q != ST_SLP_WFE)) ||
                  (accept && (is_sev || is_sevl));
  assign ev_clr = wfe_consume || wake_wfe;

  wfx_event_reg u_ev (
    .clk(clk), .rst_n(rst_n), .set_i(ev_set), .clr_i(ev_clr), .ev_q(ev_q)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (wfe_sleep)      state_d = ST_SLP_WFE;
        else if (wfi_sleep) state_d = ST_SLP_WFI;
        else if (accept)    state_d = ST_RESP;
      end
      ST_RESP:    state_d = ST_IDLE;
      ST_SLP_WFE: if (wake_wfe) state_d = ST_RESP;
      ST_SLP_WFI: if (wake_wfi) state_d = ST_RESP;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      done        <= 1'b0;
      trap_req    <= 1'b0;
      trap_el     <= '0;
      trap_is_wfi <= 1'b0;
      sev_out     <= 1'b0;
    end else begin
      state_q     <= state_d;
      done        <= (accept && !trap_any && !sleep_any) || wake_any;
      trap_req    <= trap_any;
      trap_el     <= trap_any ? tgt : '0;
      trap_is_wfi <= wfi_trap;
      sev_out     <= accept && is_sev;
    end
  end

  assign sleeping = (state_q == ST_SLP_WFE) || (state_q == ST_SLP_WFI);

  // R4
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (!done && !sleeping && (trap_el != '0)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  sev_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sev_out |=> !sev_out);
  // R10
  wfi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SLP_WFI) && !irq_pend) |=> sleeping);
  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && hint_valid && !wake_any) |=> (sleeping && !sev_out));
  // R3
  wfe_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wfe_acc && ev_q) |=> (done && !sleeping && !trap_req));
endmodule

// File: tb/wfx_sleep_ctrl_test.sv
`timescale 1ns/1ps
module wfx_sleep_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hint_valid = 1'b0;
  logic [6:0] hint_sel = '0;
  logic [1:0] cur_el = '0;
  logic el2_en = 1'b0, host_mode = 1'b0, el3_impl = 1'b0;
  logic [2:0] wfe_trap_en = '0, wfi_trap_en = '0;
  logic irq_pend = 1'b0, ext_event = 1'b0;
  logic trap_req, trap_is_wfi, sleeping, sev_out, done;
  logic [1:0] trap_el;
  int checks = 0;
  int errors = 0;

  localparam logic [6:0] C_WFE = 7'b0000010, C_WFI = 7'b0000011,
                         C_SEV = 7'b0000100, C_SEVL = 7'b0000101;

  always #2.5 clk = ~clk;

  wfx_sleep_ctrl uut (
    .clk(clk), .rst_n(rst_n), .hint_valid(hint_valid), .hint_sel(hint_sel),
    .cur_el(cur_el), .el2_en(el2_en), .host_mode(host_mode), .el3_impl(el3_impl),
    .wfe_trap_en(wfe_trap_en), .wfi_trap_en(wfi_trap_en), .irq_pend(irq_pend),
    .ext_event(ext_event), .trap_req(trap_req), .trap_el(trap_el),
    .trap_is_wfi(trap_is_wfi), .sleeping(sleeping), .sev_out(sev_out), .done(done)
  );

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // done, trap_req, trap_el, trap_is_wfi, sleeping, sev_out
  task automatic outs(input string req, input int d, input int t, input int el,
                      input int w, input int s, input int v);
    chk(int'(done), d, req, "done");
    chk(int'(trap_req), t, req, "trap_req");
    chk(int'(trap_el), el, req, "trap_el");
    chk(int'(trap_is_wfi), w, req, "trap_is_wfi");
    chk(int'(sleeping), s, req, "sleeping");
    chk(int'(sev_out), v, req, "sev_out");
  endtask

  // Called at a negedge; returns at the negedge after the accepting edge
  task automatic issue(input logic [6:0] s);
    hint_valid = 1'b1;
    hint_sel = s;
    @(posedge clk);
    #1 hint_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic wake_irq(input string req);
    irq_pend = 1'b1;
    @(posedge clk);
    #1 irq_pend = 1'b0;
    @(negedge clk);
    outs(req, 1, 0, 0, 0, 0, 0);
    settle();
  endtask

  task automatic t_reset();
    outs("R1", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_other_codes();
    issue(7'b0000000); outs("R2", 1, 0, 0, 0, 0, 0); settle();
    chk(int'(done), 0, "R2", "done after pulse");
    issue(7'b0000001); outs("R2", 1, 0, 0, 0, 0, 0); settle();
    issue(7'b0010000); outs("R2", 1, 0, 0, 0, 0, 0); settle();
  endtask

  task automatic t_wfe_sleep_wake();
    cur_el = 2'd1; wfe_trap_en = '0; wfi_trap_en = 3'b111;
    issue(C_WFE); outs("R5", 0, 0, 0, 0, 1, 0);   // R1: event register starts clear
    ext_event = 1'b1;
    @(posedge clk);
    #1 ext_event = 1'b0;
    @(negedge clk);
    outs("R9", 1, 0, 0, 0, 0, 0);
    settle();
    chk(int'(done), 0, "R9", "done one cycle");
    issue(C_WFE); outs("R9", 0, 0, 0, 0, 1, 0);   // wake event was consumed
    wake_irq("R9");
    wfi_trap_en = '0;
  endtask

  task automatic t_wfe_trap_order();
    el2_en = 1'b1; host_mode = 1'b0; el3_impl = 1'b1; cur_el = 2'd0;
    wfe_trap_en = 3'b111; issue(C_WFE); outs("R4", 0, 1, 1, 0, 0, 0); settle();
    chk(int'(trap_req), 0, "R4", "trap pulse width");
    wfe_trap_en = 3'b110; issue(C_WFE); outs("R4", 0, 1, 2, 0, 0, 0); settle();
    wfe_trap_en = 3'b100; issue(C_WFE); outs("R4", 0, 1, 3, 0, 0, 0); settle();
    host_mode = 1'b1; wfe_trap_en = 3'b010;
    issue(C_WFE); outs("R4", 0, 0, 0, 0, 1, 0); wake_irq("R4");
    host_mode = 1'b0; cur_el = 2'd1; wfe_trap_en = 3'b101;
    issue(C_WFE); outs("R4", 0, 1, 3, 0, 0, 0); settle();
    cur_el = 2'd3; wfe_trap_en = 3'b111;
    issue(C_WFE); outs("R5", 0, 0, 0, 0, 1, 0); wake_irq("R5");
    wfe_trap_en = '0;
  endtask

  task automatic t_wfi();
    cur_el = 2'd0; el2_en = 1'b1; el3_impl = 1'b1; wfi_trap_en = 3'b111;
    irq_pend = 1'b1; issue(C_WFI); outs("R6", 1, 0, 0, 0, 0, 0); settle();
    irq_pend = 1'b0;
    issue(C_WFI); outs("R7", 0, 1, 1, 1, 0, 0); settle();
    wfi_trap_en = 3'b100; issue(C_WFI); outs("R7", 0, 1, 3, 1, 0, 0); settle();
    wfi_trap_en = '0; wfe_trap_en = 3'b111;
    issue(C_WFI); outs("R7", 0, 0, 0, 0, 1, 0);
    ext_event = 1'b1;
    @(posedge clk);
    #1 ext_event = 1'b0;
    @(negedge clk);
    outs("R10", 0, 0, 0, 0, 1, 0);
    wake_irq("R10");
    issue(C_WFE); outs("R10", 1, 0, 0, 0, 0, 0); settle();   // event was latched
    wfe_trap_en = '0;
  endtask

  task automatic t_event_reg();
    cur_el = 2'd0; el2_en = 1'b1; el3_impl = 1'b1;
    ext_event = 1'b1; settle(); ext_event = 1'b0;
    wfe_trap_en = 3'b111;
    issue(C_WFE); outs("R3", 1, 0, 0, 0, 0, 0); settle();   // R11 set while idle
    issue(C_WFE); outs("R3", 0, 1, 1, 0, 0, 0); settle();   // cleared by consume
    wfe_trap_en = '0;
    ext_event = 1'b1; settle();
    hint_valid = 1'b1; hint_sel = C_WFE;
    @(posedge clk);
    #1 begin hint_valid = 1'b0; ext_event = 1'b0; end
    @(negedge clk);
    outs("R11", 1, 0, 0, 0, 0, 0); settle();
    issue(C_WFE); outs("R11", 1, 0, 0, 0, 0, 0); settle();  // set won over clear
    issue(C_WFE); outs("R11", 0, 0, 0, 0, 1, 0); wake_irq("R11");
  endtask

  task automatic t_send_event();
    wfe_trap_en = '0;
    hint_valid = 1'b1; hint_sel = C_SEV;
    @(posedge clk);
    @(negedge clk);
    outs("R8", 1, 0, 0, 0, 0, 1);
    @(posedge clk);                 // held strobe lands in the response cycle
    #1 hint_valid = 1'b0;
    @(negedge clk);
    chk(int'(sev_out), 0, "R12", "sev_out after held strobe");
    chk(int'(done), 0, "R12", "done after held strobe");
    issue(C_WFE); outs("R8", 1, 0, 0, 0, 0, 0); settle();
    issue(C_SEVL); outs("R8", 1, 0, 0, 0, 0, 0); settle();
    issue(C_WFE); outs("R8", 1, 0, 0, 0, 0, 0); settle();
  endtask

  task automatic t_ignore_sleeping();
    issue(C_WFE); outs("R12", 0, 0, 0, 0, 1, 0);
    issue(C_SEV); outs("R12", 0, 0, 0, 0, 1, 0);
    wake_irq("R12");
    issue(C_WFE); outs("R12", 0, 0, 0, 0, 1, 0);             // no event was latched
    wake_irq("R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_other_codes();
    t_wfe_sleep_wake();
    t_wfe_trap_order();
    t_wfi();
    t_event_reg();
    t_send_event();
    t_ignore_sleeping();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule